// File: doc/BRIEF.md
# Glitch-Free Card Clock Ratio Selector

This block derives a card clock from a reference clock at the full reference rate or at one half, one quarter or one eighth of it. Two select pins choose the ratio. The ratio may change while the card clock is running. A gate input from the activation sequencer starts and stops the card clock, and the output always rests at a low level when it is stopped. Everything runs on the reference clock. The only exception is the full-rate path, where the reference clock is passed through an enable that changes only while the reference is low.

All divided rates are taken from one free-running 3-bit counter, so they share the same reference edges. The counter defines an 8-cycle frame. The select and gate pins go through a short synchronizer. The settings they ask for are applied only at the frame boundary. At that point every divided waveform has just finished its low half and is about to begin a high half. As a result, a change of ratio or gate never cuts a pulse short.

Top module: `card_clk_sel`

## Requirements
- R1: The select pins {sel_a, sel_b} are decoded as 00 = divide by 8, 01 = divide by 4, 11 = divide by 2 and 10 = divide by 1. For a divisor d of 2 or more, the output is high for d/2 reference periods and then low for d/2. At divide by 1, the output follows the reference clock: high in the reference high half and low in the reference low half.
- R2: While rst is high, and from the first full reference cycle of reset onward, card_clk is low. Reset selects divide by 8 with the output stopped.
- R3: Let n count the reference rising edges since reset was released. For a divisor d of 2 or more, the output is high exactly when floor((n mod 8)/(d/2)) is even.
- R4: A new ratio or gate setting is applied only at the rising edge where n mod 8 becomes 0.
- R5: The select and gate pins pass through SYNC_STAGES flops, 2 by default. A value driven during the cycle in which n mod 8 = 7 - SYNC_STAGES is applied at the next boundary. A value driven one cycle later waits for the following boundary. Any change therefore takes effect within SYNC_STAGES + 8 reference periods.
- R6: Across any ratio change, every completed high or low phase of card_clk lasts exactly the full phase width of either the old ratio or the new ratio.
- R7: When gate_en is deasserted, the output finishes the high phase in progress, stops at the next boundary and stays low.
- R8: When gate_en is asserted, the output starts at a boundary with a full-width high phase of the selected ratio.
- R9: The full-rate enable and the divided output are never active together, so a handover to or from divide by 1 never merges two pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | Run request from the activation sequencer |
| sel_a | input | 1 | Ratio select, upper bit |
| sel_b | input | 1 | Ratio select, lower bit |
| card_clk | output | 1 | Clock sent to the card |

## Verification
A wrong frame counter or a wrong committed ratio shows up on card_clk at once. The output then sits in the wrong half of the frame, and the next sampled half-cycle already differs from the value predicted from n. A switch made away from the boundary cuts a phase short. That shortened phase is visible as soon as it completes: at most four reference periods for a divided rate, or half a period at full rate. Switching at the wrong boundary, or with the wrong synchronizer depth, moves the first changed half-cycle by a whole frame. The bench detects this one frame after the command.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    // Width of the shared frame counter: log2 of the largest divisor.
    localparam int PHASE_W = 3;

    // Each encoding value is log2 of the divisor.
    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2,
        RATIO_8 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic   run;
        ratio_e ratio;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{run: 1'b0, ratio: RATIO_8};

    // Pin decode; the code sequence is non-binary (Gray order).
    function automatic ratio_e decode_sel(input logic a, input logic b);
        ratio_e r;
        case ({a, b})
            2'b00:   r = RATIO_8;
            2'b01:   r = RATIO_4;
            2'b11:   r = RATIO_2;
            default: r = RATIO_1;
        endcase
        return r;
    endfunction

    // Level of a divided waveform at a given frame position.
    // High in the first half of each sub-period, so all ratios rise at position 0.
    function automatic logic phase_level(input ratio_e r, input logic [PHASE_W-1:0] pos);
        logic lvl;
        case (r)
            RATIO_2: lvl = ~pos[0];
            RATIO_4: lvl = ~pos[1];
            RATIO_8: lvl = ~pos[2];
            default: lvl = 1'b0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= din;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign dout = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ccs_phase_ctrl.sv
module ccs_phase_ctrl
    import card_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t cfg_req,
    output clk_cfg_t cfg_nxt,
    output logic     slow_q
);

    logic [PHASE_W-1:0] pos_q;
    logic [PHASE_W-1:0] pos_nxt;
    clk_cfg_t           cfg_q;
    logic               frame_end;
    logic               slow_d;

    assign frame_end = (pos_q == {PHASE_W{1'b1}});
    assign pos_nxt   = pos_q + 1'b1;
    assign cfg_nxt   = frame_end ? cfg_req : cfg_q;
    assign slow_d    = cfg_nxt.run & phase_level(cfg_nxt.ratio, pos_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            cfg_q  <= CFG_RESET;
            slow_q <= 1'b0;
        end else begin
            pos_q  <= pos_nxt;
            cfg_q  <= cfg_nxt;
            slow_q <= slow_d;
        end
    end

    // R4: the applied setting only moves on the frame boundary
    assert_cfg_at_frame_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> (pos_q == '0));

    // R1: the divided path stays quiet while full rate is selected
    assert_full_rate_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.ratio == RATIO_1) |-> !slow_q);

    // R7: a stop never leaves the divided output high
    assert_stop_low_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_q.run) |-> !slow_q);

    // R8: a divided start opens with a high phase
    assert_start_high_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_q.run) && cfg_q.ratio != RATIO_1) |-> slow_q);

endmodule

// File: rtl/ccs_fast_gate.sv
module ccs_fast_gate (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic fast_en
);

    // Updated on the falling edge, so the enable only moves while clk is low.
    always_ff @(negedge clk) begin
        if (rst) fast_en <= 1'b0;
        else     fast_en <= arm;
    end

endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
    import card_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic sel_a,
    input  logic sel_b,
    output logic card_clk
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    clk_cfg_t         cfg_req;
    clk_cfg_t         cfg_nxt;
    logic             slow_q;
    logic             fast_en;
    logic             fast_arm;

    ccs_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({gate_en, sel_a, sel_b}),
        .dout (pins_s)
    );

    assign cfg_req.run   = pins_s[2];
    assign cfg_req.ratio = decode_sel(pins_s[1], pins_s[0]);

    ccs_phase_ctrl u_phase (
        .clk     (clk),
        .rst     (rst),
        .cfg_req (cfg_req),
        .cfg_nxt (cfg_nxt),
        .slow_q  (slow_q)
    );

    assign fast_arm = cfg_nxt.run && (cfg_nxt.ratio == RATIO_1);

    ccs_fast_gate u_fast (
        .clk     (clk),
        .rst     (rst),
        .arm     (fast_arm),
        .fast_en (fast_en)
    );

    assign card_clk = slow_q | (clk & fast_en);

    // R9: full-rate enable and divided output are never active together
    assert_paths_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(fast_en && slow_q));

endmodule

// File: tb/card_clk_sel_test.sv
`timescale 1ns/1ps
module card_clk_sel_test;

    localparam int SYNC = 2;
    localparam int NV   = 13;
    // {gate_en, sel_a, sel_b}
    localparam logic [2:0] VEC [NV] = '{
        3'b100, 3'b101, 3'b111, 3'b110, 3'b111, 3'b101, 3'b100,
        3'b110, 3'b010, 3'b100, 3'b101, 3'b001, 3'b111
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gate_en = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic card_clk;

    int checks = 0;
    int fails  = 0;
    int bcnt   = 0;
    logic s_hi, s_lo;

    // run-width monitor state
    bit   mon_en = 1'b0;
    int   runs_seen = 0;
    int   run_len = 0;
    logic cur_v = 1'b0;
    int   wa = 8, wb = 8;

    card_clk_sel #(.SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .gate_en(gate_en),
        .sel_a(sel_a), .sel_b(sel_b), .card_clk(card_clk)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) bcnt <= 0;
        else     bcnt <= bcnt + 1;
    end

    function automatic int divisor(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 8;
            2'b01:   return 4;
            2'b11:   return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic exp_level(input logic g, input logic a, input logic b,
                                       input int n, input bit hi_half);
        int d;
        d = divisor(a, b);
        if (!g) return 1'b0;
        if (d == 1) return hi_half;
        return (((n % 8) / (d / 2)) % 2) == 0;
    endfunction

    task automatic check(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s n=%0d actual=%b expected=%b", tag, bcnt, act, expv);
        end
    endtask

    task automatic track(input logic v);
        if (v === cur_v) begin
            run_len++;
        end else begin
            if (mon_en && runs_seen > 0) begin
                checks++;
                if (run_len != wa && run_len != wb) begin
                    fails++;
                    $display("FAIL R6 n=%0d phase width actual=%0d expected=%0d or %0d",
                             bcnt, run_len, wa, wb);
                end
            end
            runs_seen++;
            cur_v = v;
            run_len = 1;
        end
    endtask

    // one reference cycle: sample high half, then low half; returns in the low half
    task automatic step();
        @(posedge clk); #1;
        s_hi = card_clk;
        track(s_hi);
        @(negedge clk); #1;
        s_lo = card_clk;
        track(s_lo);
    endtask

    task automatic steady(input string tag);
        for (int k = 0; k < 16; k++) begin
            step();
            check(tag, s_hi, exp_level(gate_en, sel_a, sel_b, bcnt, 1'b1));
            check(tag, s_lo, exp_level(gate_en, sel_a, sel_b, bcnt, 1'b0));
        end
    endtask

    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [2:0] prev;
        gate_en = 1'b1; sel_a = 1'b0; sel_b = 1'b0;
        step();
        // R2: output held low during reset
        for (int k = 0; k < 3; k++) begin
            step();
            check("R2 reset", s_hi, 1'b0);
            check("R2 reset", s_lo, 1'b0);
        end
        rst = 1'b0;
        // R8/R5: gate seen after sync, first full high at n=8 for 4 periods
        for (int k = 0; k < 16; k++) begin
            step();
            check("R8 start", s_hi, (bcnt >= 8) && ((bcnt % 8) < 4));
            check("R8 start", s_lo, (bcnt >= 8) && ((bcnt % 8) < 4));
        end

        // vector walk: R1/R3 steady patterns, R6/R7/R8 around each change
        prev = 3'b100;
        runs_seen = 0;
        for (int i = 0; i < NV; i++) begin
            logic [2:0] v;
            v = VEC[i];
            if (!prev[2]) runs_seen = 0;
            wa = divisor(prev[1], prev[0]);
            wb = v[2] ? divisor(v[1], v[0]) : wa;
            if (!prev[2]) wa = wb;
            mon_en = 1'b1;
            gate_en = v[2]; sel_a = v[1]; sel_b = v[0];
            for (int k = 0; k < SYNC + 18; k++) step();
            steady(v[2] ? "R1 R3 steady" : "R7 stopped");
            prev = v;
        end

        // move to divide by 8 one bit at a time
        mon_en = 1'b0;
        sel_a = 1'b0; sel_b = 1'b1;
        for (int k = 0; k < 20; k++) step();
        sel_b = 1'b0;
        for (int k = 0; k < 20; k++) step();
        steady("R1 div8");

        // R5: driven at frame position 7-SYNC -> applied at the next boundary
        do step(); while ((bcnt % 8) != 7 - SYNC);
        sel_b = 1'b1;   // divide by 4
        do step(); while ((bcnt % 8) != 2);
        check("R5 applied", s_hi, 1'b0);
        check("R5 applied", s_lo, 1'b0);

        // R4/R5: driven one cycle later -> held until the following boundary
        do step(); while ((bcnt % 8) != 8 - SYNC);
        sel_a = 1'b1;   // divide by 2
        do step(); while ((bcnt % 8) != 1);
        check("R4 deferred", s_hi, 1'b1);
        check("R4 deferred", s_lo, 1'b1);
        do step(); while ((bcnt % 8) != 1);
        check("R5 late apply", s_hi, 1'b0);
        check("R5 late apply", s_lo, 1'b0);

        // R2: reset during full-rate output returns to low
        sel_b = 1'b0;
        for (int k = 0; k < 20; k++) step();
        check("R1 full rate", s_hi, 1'b1);
        check("R1 full rate", s_lo, 1'b0);
        rst = 1'b1;
        step();
        for (int k = 0; k < 3; k++) begin
            step();
            check("R2 reset mid-run", s_hi, 1'b0);
            check("R2 reset mid-run", s_lo, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule